// File: doc/BRIEF.md
# Horizontal Variable-Phase Resampling Scaler

This block resamples one video line of luma and interleaved chroma by a freely programmable ratio. A line arrives as a valid-qualified pixel stream framed by start and end markers and is held in an internal line store. Once the end marker arrives, the block stops accepting input. A position accumulator then walks across the stored line in steps of 1/1024 pixel. At each position the block produces one scaled output pixel from a 10-tap luma interpolator and a 4-tap chroma interpolator.

The fractional part of the position is reduced to one of 64 phases. The filter weights for each phase come from closed-form kernels, so no coefficient table is stored. Luma and chroma each have their own step and start offset. For correct results, the chroma values are set to half the luma values, because chroma is sampled at half the luma rate. Steps from about 293 (zoom near 3.5x) up to 8191 (downscale near 1/8) are usable. Steps between 512 and 2048 give the best results.

Top module: `hscale_resampler`

## Requirements
- R1: While reset is held, and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A pixel is taken only on a rising edge where `in_valid` and `in_ready` are both 1. Cycles with `in_valid` at 0 change nothing, whatever the data and marker inputs carry.
- R3: A taken pixel with `in_sol` set becomes index 0 of a new line, and any unfinished line is discarded. A taken pixel with `in_eol` set closes a line of L pixels. `in_ready` stays 0 from the next edge until the edge that registers the last output of that line.
- R4: Output n of a line sits at luma position P = 32*`ofs_y` + n*`inc_y`, in units of 1/1024 pixel. Outputs are produced for every n whose index i = P>>10 is below L. `out_last` is 1 on the output for which (P+`inc_y`)>>10 is at least L. A line whose first position already lies at or beyond L produces no output.
- R5: Luma output = (S+512)>>10, where S sums, over taps k = 0..9, the weight min(128, max(0, 320-|64(k-4)-f|)) times pixel i+k-4. The phase is f = (P>>4) mod 64. The weights always total 1024.
- R6: Every pixel index that falls outside the line is clamped to the first or last pixel of the line, for both luma and chroma.
- R7: `in_c` carries Cb on even pixel indices and Cr on odd ones. For output n, the chroma position is Q = 32*`ofs_c` + n*`inc_c`, in 1/1024 of a Cb/Cr pair. Output n carries Cb when n is even and Cr when n is odd.
- R8: Chroma output = (T+128)>>8, where T sums, over taps k = 0..3, the weight 128-|64(k-1)-g| times the chroma sample of pair j+k-1. Here j = Q>>10 and g = (Q>>4) mod 64. The pair index is clamped to 0..max(1,L/2)-1. The buffer address 2*pair+parity is clamped to L-1.
- R9: A line of one constant value is reproduced unchanged at every phase, including the value 255 (unity gain, results saturate at 255).
- R10: The outputs of a line come on consecutive cycles, one per cycle. With a step below 1024, several outputs are produced per input pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take a pixel |
| in_y | input | 8 | Input luma |
| in_c | input | 8 | Input chroma, Cb on even and Cr on odd pixels |
| in_sol | input | 1 | Pixel is the first of a line |
| in_eol | input | 1 | Pixel is the last of a line |
| inc_y | input | 13 | Luma step, 1024 = one input pixel per output |
| inc_c | input | 13 | Chroma step, set to half of inc_y |
| ofs_y | input | 8 | Luma start offset, 1/32 pixel units |
| ofs_c | input | 8 | Chroma start offset, set to half of ofs_y |
| out_valid | output | 1 | Output pixel present |
| out_y | output | 8 | Scaled luma |
| out_c | output | 8 | Scaled chroma, Cb then Cr alternating |
| out_last | output | 1 | Last output of the line |

## Verification
The accumulators and the line store are only visible through the output values. A wrong step, offset or phase bit changes the computed luma and chroma from the first output of a line. A wrong line length or end test shows as a missing or extra output, or as a misplaced `out_last`, by the end of that line. A chroma parity slip swaps Cb and Cr on the very next output. A corrupted write pointer shows as wrong values at the line edges, where replication would otherwise hide nothing.

// File: rtl/hscale_resampler.sv
module hscale_resampler #(
  parameter int MAX_PIX = 256,
  parameter int INC_W   = 13,
  parameter int OFS_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_y,
  input  logic [7:0]       in_c,
  input  logic             in_sol,
  input  logic             in_eol,
  input  logic [INC_W-1:0] inc_y,
  input  logic [INC_W-1:0] inc_c,
  input  logic [OFS_W-1:0] ofs_y,
  input  logic [OFS_W-1:0] ofs_c,
  output logic             out_valid,
  output logic [7:0]       out_y,
  output logic [7:0]       out_c,
  output logic             out_last
);

  localparam int IDX_W  = $clog2(MAX_PIX);
  localparam int LEN_W  = IDX_W + 1;
  localparam int FRAC_W = 10;
  localparam int PH_W   = 6;
  localparam int PH_N   = 1 << PH_W;
  localparam int ACC_W  = LEN_W + INC_W + 1;
  localparam int OFS_SH = FRAC_W - 5;
  localparam int Y_TAPS = 10;
  localparam int Y_MID  = 4;
  localparam int C_TAPS = 4;
  localparam int C_MID  = 1;
  localparam int Y_SH   = 10;
  localparam int C_SH   = 8;

  logic [7:0]       ybuf [MAX_PIX];
  logic [7:0]       cbuf [MAX_PIX];
  logic             emit, par, take, have, last;
  logic [LEN_W-1:0] wr_ptr, wr_idx, len;
  logic [ACC_W-1:0] acc_y, acc_c, nxt_y;
  logic [7:0]       y_res, c_res;

  assign in_ready = !emit;
  assign take     = in_valid && !emit;
  assign wr_idx   = in_sol ? '0 : wr_ptr;
  assign nxt_y    = acc_y + ACC_W'(inc_y);
  assign have     = (acc_y >> FRAC_W) < ACC_W'(len);
  assign last     = (nxt_y >> FRAC_W) >= ACC_W'(len);

  always_ff @(posedge clk) begin
    if (take && wr_idx < LEN_W'(MAX_PIX)) begin
      ybuf[wr_idx[IDX_W-1:0]] <= in_y;
      cbuf[wr_idx[IDX_W-1:0]] <= in_c;
    end
  end

  always_comb begin
    int base, ph, t, d, w, sum;
    base = int'(acc_y >> FRAC_W);
    ph   = int'(acc_y[FRAC_W-1:FRAC_W-PH_W]);
    sum  = 0;
    for (int k = 0; k < Y_TAPS; k++) begin
      t = base + k - Y_MID;
      if (t > int'(len) - 1) t = int'(len) - 1;
      if (t < 0) t = 0;
      d = PH_N * (k - Y_MID) - ph;
      if (d < 0) d = -d;
      w = 5 * PH_N - d;
      if (w > 2 * PH_N) w = 2 * PH_N;
      if (w < 0) w = 0;
      sum += w * int'(ybuf[t[IDX_W-1:0]]);
    end
    sum = (sum + (1 << (Y_SH - 1))) >>> Y_SH;
    if (sum > 255) sum = 255;
    y_res = sum[7:0];
  end

  always_comb begin
    int base, ph, np, t, a, d, w, sum;
    base = int'(acc_c >> FRAC_W);
    ph   = int'(acc_c[FRAC_W-1:FRAC_W-PH_W]);
    np   = int'(len) >>> 1;
    if (np < 1) np = 1;
    sum  = 0;
    for (int k = 0; k < C_TAPS; k++) begin
      t = base + k - C_MID;
      if (t > np - 1) t = np - 1;
      if (t < 0) t = 0;
      a = 2 * t + int'(par);
      if (a > int'(len) - 1) a = int'(len) - 1;
      if (a < 0) a = 0;
      d = PH_N * (k - C_MID) - ph;
      if (d < 0) d = -d;
      w = 2 * PH_N - d;
      if (w < 0) w = 0;
      sum += w * int'(cbuf[a[IDX_W-1:0]]);
    end
    sum = (sum + (1 << (C_SH - 1))) >>> C_SH;
    if (sum > 255) sum = 255;
    c_res = sum[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emit      <= 1'b0;
      par       <= 1'b0;
      wr_ptr    <= '0;
      len       <= '0;
      acc_y     <= '0;
      acc_c     <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_y     <= '0;
      out_c     <= '0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      if (take) begin
        wr_ptr <= (wr_idx < LEN_W'(MAX_PIX)) ? wr_idx + 1'b1 : wr_idx;
        if (in_eol) begin
          emit   <= 1'b1;
          wr_ptr <= '0;
          len    <= (wr_idx < LEN_W'(MAX_PIX)) ? wr_idx + 1'b1 : wr_idx;
          acc_y  <= ACC_W'(ofs_y) << OFS_SH;
          acc_c  <= ACC_W'(ofs_c) << OFS_SH;
          par    <= 1'b0;
        end
      end else if (emit) begin
        if (have) begin
          out_valid <= 1'b1;
          out_y     <= y_res;
          out_c     <= c_res;
          out_last  <= last;
          acc_y     <= nxt_y;
          acc_c     <= acc_c + ACC_W'(inc_c);
          par       <= ~par;
          if (last) emit <= 1'b0;
        end else begin
          emit <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/hscale_resampler_chk.sv
module hscale_resampler_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic in_eol,
  input logic out_valid,
  input logic out_last
);

  assert_stall_after_eol_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_eol |=> !in_ready);

  assert_no_input_mid_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |-> !in_ready);

  assert_gap_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |=> !out_valid);

  assert_last_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_quiet_while_filling_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && $past(in_ready) |-> !out_valid);

endmodule

bind hscale_resampler hscale_resampler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_eol(in_eol), .out_valid(out_valid), .out_last(out_last)
);

// File: tb/test_hscale_resampler.sv
module test_hscale_resampler;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        in_valid = 1'b0, in_sol = 1'b0, in_eol = 1'b0;
  logic        in_ready, out_valid, out_last;
  logic [7:0]  in_y = 8'd0, in_c = 8'd0, out_y, out_c;
  logic [12:0] inc_y = 13'd1024, inc_c = 13'd512;
  logic [7:0]  ofs_y = 8'd0, ofs_c = 8'd0;

  hscale_resampler i_hscale_resampler (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_y(in_y), .in_c(in_c), .in_sol(in_sol), .in_eol(in_eol),
    .inc_y(inc_y), .inc_c(inc_c), .ofs_y(ofs_y), .ofs_c(ofs_c),
    .out_valid(out_valid), .out_y(out_y), .out_c(out_c), .out_last(out_last)
  );

  int checks = 0, errors = 0, cyc = 0, got_n = 0, exp_n = 0;
  int lcg = 7;
  int exp_y[$], exp_c[$], exp_l[$], pix_y[$], pix_c[$];
  bit run_on = 0;
  string ytag = "R5", ctag = "R8";

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic int rnd();
    lcg = lcg * 1103515245 + 12345;
    return (lcg >>> 16) & 255;
  endfunction

  function automatic void model();
    int L = pix_y.size();
    int np = (L / 2 < 1) ? 1 : L / 2;
    for (int n = 0; ; n++) begin
      int p = int'(ofs_y) * 32 + n * int'(inc_y);
      int q = int'(ofs_c) * 32 + n * int'(inc_c);
      int i = p >> 10, f = (p >> 4) & 63, j = q >> 10, g = (q >> 4) & 63;
      int sy = 0, sc = 0;
      if (i >= L) break;
      for (int k = 0; k < 10; k++) begin
        int x = i + k - 4, d = 64 * (k - 4) - f, w;
        if (x < 0) x = 0;
        if (x > L - 1) x = L - 1;
        if (d < 0) d = -d;
        w = 320 - d;
        if (w > 128) w = 128;
        if (w < 0) w = 0;
        sy += w * pix_y[x];
      end
      for (int k = 0; k < 4; k++) begin
        int s = j + k - 1, d = 64 * (k - 1) - g, a;
        if (s < 0) s = 0;
        if (s > np - 1) s = np - 1;
        a = 2 * s + (n % 2);
        if (a > L - 1) a = L - 1;
        if (d < 0) d = -d;
        sc += (128 - d) * pix_c[a];
      end
      sy = (sy + 512) >> 10;
      sc = (sc + 128) >> 8;
      exp_y.push_back(sy > 255 ? 255 : sy);
      exp_c.push_back(sc > 255 ? 255 : sc);
      exp_l.push_back(((p + int'(inc_y)) >> 10) >= L ? 1 : 0);
    end
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (exp_y.size() == 0) chk(0, "R4", "unexpected output", 1, 0);
        else begin
          chk(out_y == exp_y[0], ytag, "luma", out_y, exp_y[0]);
          chk(out_c == exp_c[0], ctag, "chroma", out_c, exp_c[0]);
          chk(out_last == exp_l[0], "R4", "last flag", out_last, exp_l[0]);
          void'(exp_y.pop_front()); void'(exp_c.pop_front()); void'(exp_l.pop_front());
        end
        if (!out_last) chk(in_ready == 0, "R3", "ready during emission", in_ready, 0);
        got_n++;
        run_on = !out_last;
      end else if (run_on) begin
        chk(0, "R10", "gap inside output run", 0, 1);
        run_on = 0;
      end
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual %0d expected %0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic put_pix(int y, int c, bit s, bit e);
    @(negedge clk);
    in_valid = 1; in_y = 8'(y); in_c = 8'(c); in_sol = s; in_eol = e;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    in_valid = 0; in_y = 8'hFF; in_c = 8'hFF; in_sol = 1; in_eol = 1;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic cfg(int iy, int ic, int oy, int oc, string ty, string tc);
    @(negedge clk);
    inc_y = 13'(iy); inc_c = 13'(ic); ofs_y = 8'(oy); ofs_c = 8'(oc);
    ytag = ty; ctag = tc;
  endtask

  task automatic run_line(int L, int kind, int base, bit gaps);
    pix_y.delete(); pix_c.delete();
    for (int p = 0; p < L; p++) begin
      if (kind == 0) begin pix_y.push_back((base + 7 * p) & 255); pix_c.push_back((3 * base + 11 * p) & 255); end
      else if (kind == 1) begin pix_y.push_back(rnd()); pix_c.push_back(rnd()); end
      else begin pix_y.push_back(base); pix_c.push_back(base); end
    end
    for (int p = 0; p < L; p++) begin
      put_pix(pix_y[p], pix_c[p], p == 0, p == L - 1);
      if (p == L - 1) begin
        got_n = 0;
        model();
        exp_n = exp_y.size();
      end else if (gaps && p % 3 == 1) idle(2);
    end
    idle(1);
    while (!(in_ready && exp_y.size() == 0)) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(got_n == exp_n, "R4", "outputs per line", got_n, exp_n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
    chk(in_ready == 1, "R1", "in_ready in reset", in_ready, 1);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);

    cfg(1024, 512, 0, 0, "R5", "R8");      run_line(16, 0, 20, 0);
    cfg(2048, 1024, 16, 8, "R5", "R7");    run_line(24, 1, 0, 0);
    cfg(300, 150, 3, 1, "R10", "R8");      run_line(10, 1, 0, 0);
    cfg(8191, 4095, 40, 20, "R4", "R7");   run_line(64, 0, 5, 0);
    cfg(777, 388, 5, 2, "R9", "R9");       run_line(20, 2, 200, 0);
    cfg(1536, 768, 9, 4, "R9", "R9");      run_line(8, 2, 255, 0);
    cfg(1024, 512, 255, 127, "R4", "R4");  run_line(4, 0, 9, 0);
    cfg(512, 256, 0, 0, "R6", "R6");       run_line(1, 0, 77, 0);
    cfg(1024, 512, 8, 4, "R3", "R3");
    put_pix(250, 250, 1, 0); put_pix(250, 250, 0, 0); put_pix(250, 250, 0, 0);
    run_line(12, 0, 40, 0);
    cfg(1536, 768, 4, 2, "R2", "R2");      run_line(18, 1, 0, 1);
    cfg(640, 320, 50, 25, "R6", "R8");     run_line(6, 1, 0, 0);

    summary();
    $finish;
  end
endmodule